// File: doc/BRIEF.md
# Serial DAC Front End

This block is the digital input stage of a voltage-output digital-to-analog converter. A host sends a 16-bit frame, most significant bit first, over a three-wire serial link. The link has an active-low chip select `cs_n`, a serial clock `sclk` and a data line `sdi`. The block shifts the frame into a holding register. When chip select returns high, it moves the frame into the code latch that drives the converter.

The resolution parameter selects a 16-, 14- or 12-bit code. The code always sits left-justified in the frame, so at lower resolutions the trailing bits are dropped. The polarity parameter selects the value that power-on reset and the asynchronous clear force into the latch:
- unipolar: zero;
- bipolar: the midscale code.

A frame with fewer than 16 clock edges leaves the latch unchanged and raises a sticky error flag. A frame with more than 16 edges delivers its last 16 bits.

The serial pins are sampled by the system clock `clk`. Each pin passes through a synchronizer of `SYNC_STAGES` flops. Each `sclk` level must therefore last at least `SYNC_STAGES + 1` clock periods, and so must each `cs_n` level.

Top module: `serdac_front_end`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts in one bit from `sdi`. The first bit received ends up as frame bit 15 (MSB) and the 16th bit as bit 0.
- R2: A rising edge of `cs_n` after exactly 16 `sclk` rising edges copies the frame into the latch.
- R3: `dac_code` is frame bits [15 -: RES_BITS]. At 14 bits the 2 trailing bits are ignored, and at 12 bits the 4 trailing bits are ignored.
- R4: A frame with more than 16 edges loads the last 16 bits received. The 5-bit edge counter saturates at 31, so a frame of 40 edges is still a long frame.
- R5: A frame with fewer than 16 edges, including zero edges, leaves `dac_code` unchanged and sets `frame_err`.
- R6: `frame_err` stays set across further short frames and clears on the next frame of 16 or more edges.
- R7: While `cs_n` is high, `sclk` and `sdi` have no effect. Edges seen then neither shift data nor count toward the next frame.
- R8: While `rst_n` is low, and after it is released, `dac_code` holds the reset value and `frame_err` is 0. The reset value is 0 when unipolar (BIPOLAR=0) and 2^(RES_BITS-1) when bipolar (32768, 8192 or 2048).
- R9: `clr_n` low forces `dac_code` to the reset value at once, with no `clk` edge needed. It leaves `frame_err` unchanged.
- R10: With SYNC_STAGES=2, `dac_code` takes its new value on the third rising `clk` edge after `cs_n` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of the code latch |
| cs_n | input | 1 | Active-low chip select, frames the transfer |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | RES_BITS | Latched converter code |
| frame_err | output | 1 | Sticky flag: the last rejected frame was short |

## Verification
The bench goes after the edge count that separates frames.

Each frame is checked for the following:
- **15 or 17 edges.** A design with an off-by-one counter would reject a 16-edge frame or accept a 15-edge one.
- **40 edges.** A counter that wraps instead of saturating would call this frame short.
- **Clock pulses while deselected, then a 12-edge frame.** A design that counts edges outside the frame would wrongly load this frame.

Three instances run side by side: 16-bit unipolar, 14-bit bipolar and 12-bit bipolar. Together they expose a right-justified slice or a wrong midscale value. The clear is pulsed between clock edges, so a synchronous-only clear would show a stale code.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  typedef enum logic [1:0] {
    FRAME_SHORT = 2'd0,
    FRAME_EXACT = 2'd1,
    FRAME_LONG  = 2'd2
  } frame_kind_e;

  // Width of a saturating counter that must tell "below", "equal" and
  // "above" a frame length apart.
  function automatic int unsigned edge_cnt_width(int unsigned frame_bits);
    return $clog2(frame_bits) + 1;
  endfunction

  // Sort an edge count into short / exact / long.
  function automatic frame_kind_e classify_frame(int unsigned edges,
                                                 int unsigned frame_bits);
    if (edges < frame_bits)       return FRAME_SHORT;
    else if (edges == frame_bits) return FRAME_EXACT;
    else                          return FRAME_LONG;
  endfunction

  // Value loaded by power-on reset and by clear.
  function automatic int unsigned idle_code(int unsigned res_bits, bit bipolar);
    return bipolar ? (32'd1 << (res_bits - 1)) : 32'd0;
  endfunction

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/serdac_rise_det.sv
module serdac_rise_det #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;

endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter
  import serdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned CNT_W = edge_cnt_width(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_lvl,
  input  logic                  cs_rise,
  input  logic                  sclk_rise,
  input  logic                  sdi_lvl,
  output logic [FRAME_BITS-1:0] shift_word,
  output logic [CNT_W-1:0]      edge_cnt,
  output logic                  frame_done,
  output frame_kind_e           frame_kind
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic take_bit;
  assign take_bit = !cs_lvl && sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_word <= '0;
    end else if (take_bit) begin
      shift_word <= {shift_word[FRAME_BITS-2:0], sdi_lvl};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
    end else if (cs_lvl) begin
      edge_cnt <= '0;
    end else if (take_bit && (edge_cnt != CNT_MAX)) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign frame_done = cs_rise;
  assign frame_kind = classify_frame(32'(edge_cnt), FRAME_BITS);

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> (edge_cnt == '0)); // R7
  AST_IDLE_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(shift_word)); // R7
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && edge_cnt == CNT_MAX) |=> (edge_cnt == CNT_MAX)); // R4

endmodule

// File: rtl/serdac_latch.sv
module serdac_latch
  import serdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned RES_BITS = 16,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  frame_done,
  input  frame_kind_e           frame_kind,
  input  logic [FRAME_BITS-1:0] shift_word,
  output logic [RES_BITS-1:0]   code,
  output logic                  err
);

  localparam logic [RES_BITS-1:0] RST_CODE = RES_BITS'(idle_code(RES_BITS, BIPOLAR));

  logic                load_ok;
  logic                reject;
  logic [RES_BITS-1:0] top_bits;

  assign load_ok  = frame_done && (frame_kind != FRAME_SHORT);
  assign reject   = frame_done && (frame_kind == FRAME_SHORT);
  assign top_bits = shift_word[FRAME_BITS-1 -: RES_BITS];

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n || !clr_n) code <= RST_CODE;
    else if (load_ok)     code <= top_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (reject)  err <= 1'b1;
    else if (load_ok) err <= 1'b0;
  end

  AST_SHORT_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    reject |=> $stable(code)); // R5
  AST_SHORT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err); // R5
  AST_VALID_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !frame_done) |=> err); // R6
  AST_LOAD_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load_ok |=> (code == $past(shift_word[FRAME_BITS-1 -: RES_BITS]))); // R3
  AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code == RST_CODE)); // R9

endmodule

// File: rtl/serdac_front_end.sv
module serdac_front_end
  import serdac_pkg::*;
#(
  parameter int unsigned RES_BITS = 16,
  parameter bit BIPOLAR = 1'b0,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  output logic [RES_BITS-1:0] dac_code,
  output logic                frame_err
);

  localparam int unsigned CNT_W = edge_cnt_width(FRAME_BITS);

  // Synchronized pin levels: {cs_n, sclk, sdi}; chip select idles high.
  logic [2:0] pins_s;
  logic       cs_lvl, sclk_lvl, sdi_lvl;
  logic [1:0] rises;
  logic       cs_rise, sclk_rise;

  logic [FRAME_BITS-1:0] shift_word;
  logic [CNT_W-1:0]      edge_cnt;
  logic                  frame_done;
  frame_kind_e           frame_kind;

  serdac_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  assign cs_lvl   = pins_s[2];
  assign sclk_lvl = pins_s[1];
  assign sdi_lvl  = pins_s[0];

  serdac_rise_det #(.W(2), .RST_VAL(2'b10)) u_rise (
    .clk(clk), .rst_n(rst_n), .level({cs_lvl, sclk_lvl}), .rise(rises)
  );

  assign cs_rise   = rises[1];
  assign sclk_rise = rises[0];

  serdac_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sdi_lvl(sdi_lvl), .shift_word(shift_word),
    .edge_cnt(edge_cnt), .frame_done(frame_done), .frame_kind(frame_kind)
  );

  serdac_latch #(.FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS), .BIPOLAR(BIPOLAR)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_done(frame_done),
    .frame_kind(frame_kind), .shift_word(shift_word), .code(dac_code),
    .err(frame_err)
  );

  AST_CODE_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !frame_done |=> $stable(dac_code)); // R2
  AST_SHORT_COUNT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && edge_cnt < CNT_W'(FRAME_BITS)) |=> frame_err); // R5

endmodule

// File: tb/serdac_front_end_tb.sv
`timescale 1ns/1ps
module serdac_front_end_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;

  logic [15:0] code16;
  logic [13:0] code14;
  logic [11:0] code12;
  logic        err16, err14, err12;

  always #2 clk = ~clk; // 250 MHz

  serdac_front_end #(.RES_BITS(16), .BIPOLAR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_code(code16), .frame_err(err16));
  serdac_front_end #(.RES_BITS(14), .BIPOLAR(1'b1)) u_dut14 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_code(code14), .frame_err(err14));
  serdac_front_end #(.RES_BITS(12), .BIPOLAR(1'b1)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_code(code12), .frame_err(err12));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  bit settle = 1'b0;

  // Reference model state
  int exp16 = 0, exp14 = 8192, exp12 = 2048;
  bit exp_err = 1'b0;

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "code16", int'(code16), exp16);
    check(req, "code14", int'(code14), exp14);
    check(req, "code12", int'(code12), exp12);
    check(req, "err16", int'(err16), int'(exp_err));
    check(req, "err14", int'(err14), int'(exp_err));
    check(req, "err12", int'(err12), int'(exp_err));
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock comparison against the model outside update windows
  always @(negedge clk) begin
    if (mon_on && !settle) check_all("MON");
  end

  task automatic clear_to_reset();
    exp16 = 0; exp14 = 8192; exp12 = 2048;
  endtask

  // Send n bits, bits[n-1] first; returns after chip select high and settling.
  task automatic send_frame(input logic [63:0] bits, input int n, input string req);
    int old16;
    logic [15:0] w;
    old16 = exp16;
    nwait(1);
    cs_n = 1'b0;
    nwait(3);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      nwait(3);
      sclk = 1'b1;
      nwait(3);
      sclk = 1'b0;
    end
    nwait(3);
    settle = 1'b1;
    cs_n = 1'b1;
    w = bits[15:0];
    nwait(2);
    // R10: still the old code after two rising edges
    check("R10", "code16 before update", int'(code16), old16);
    nwait(1);
    if (n >= 16) begin
      exp16 = int'(w);
      exp14 = int'(w >> 2);
      exp12 = int'(w >> 4);
      exp_err = 1'b0;
      // R10: new code on the third rising edge
      check("R10", "code16 on third edge", int'(code16), exp16);
    end else begin
      exp_err = 1'b1;
    end
    nwait(3);
    check_all(req);
    settle = 1'b0;
  endtask

  initial begin
    nwait(3);
    // R8: during reset
    check_all("R8");
    rst_n = 1'b1;
    nwait(4);
    check_all("R8");
    mon_on = 1'b1;

    send_frame(64'hA5C3, 16, "R1");
    send_frame(64'h1234, 16, "R2");
    // R3: trailing bits ignored at 14 and 12 bits
    send_frame(64'h8003, 16, "R3");
    send_frame(64'h000F, 16, "R3");
    // R4: long frame, last 16 bits kept
    send_frame(64'hF_0F0F, 20, "R4");
    send_frame(64'h1_ACE1, 17, "R4");
    // R5: short frames
    send_frame(64'h7FFF, 15, "R5");
    send_frame(64'h0, 0, "R5");
    check("R6", "err16 sticky", int'(err16), 1);

    // R9: asynchronous clear between clock edges, error flag untouched
    @(posedge clk);
    #1;
    clr_n = 1'b0;
    clear_to_reset();
    #0.5;
    check_all("R9");
    nwait(2);
    clr_n = 1'b1;
    nwait(2);
    check_all("R9");

    // R6: valid frame clears the flag
    send_frame(64'hFFFF, 16, "R6");

    // R7: pulses while deselected must not count toward the next frame
    for (int k = 0; k < 6; k++) begin
      sdi = k[0];
      nwait(3);
      sclk = 1'b1;
      nwait(3);
      sclk = 1'b0;
    end
    nwait(2);
    check_all("R7");
    send_frame(64'h0ABC, 12, "R7");
    for (int k = 0; k < 4; k++) begin
      nwait(3);
      sclk = 1'b1;
      nwait(3);
      sclk = 1'b0;
    end
    send_frame(64'h6D2B, 16, "R7");

    // R4: 40 edges saturate the counter, still a long frame
    send_frame(64'hAB_CDEF_1357, 40, "R4");

    nwait(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule